// File: doc/BRIEF.md
# DMA Interrupt Status and Clear Unit

This unit gathers per-channel event pulses from a 16-channel DMA engine and turns them into software-visible interrupt state. Every channel can raise four kinds of event: completion of a whole descriptor chain, completion of a single node within a chain, and two independent error kinds. Each pulse sets a sticky raw bit. The bit stays set until software clears it.

Each event kind has its own enable mask. Software reads the raw bits ANDed with that mask for each kind. A summary word has one bit per channel, and that bit is set when any of the channel's four enabled events is pending. The unit drives one registered interrupt line, which is the OR of the summary. Software acknowledges events by writing ones to the clear register of each kind. To stop a channel completely, it writes that channel's bit to all four clear registers. The register port also holds a channel priority word and reflects a per-channel busy vector that the channels supply.

Top module: `dma_irq_status`

## Requirements
- R1: An event pulse on a channel of any kind sets that channel's raw bit for that kind at the next clock edge. The bit then stays set until it is cleared.
- R2: The enabled status of each kind is readable at 0x04 (chain done), 0x08 (node done), 0x0C (error A) and 0x10 (error B). Each reads as the raw bits ANDed with that kind's mask, with bit n holding channel n.
- R3: The mask registers are read/write at 0x18, 0x1C, 0x20 and 0x24, in the same kind order. A 1 enables a channel, and all masks reset to 0.
- R4: Writing a value to 0x600, 0x608, 0x610 or 0x618 (same kind order) clears exactly the raw bits of that kind that are 1 in the written value. Reading one of these offsets returns the raw bits of that kind.
- R5: If an event pulse and a clear write hit the same raw bit in the same cycle, the bit ends up set.
- R6: The summary at 0x00 has bit n set exactly when channel n has at least one enabled pending event of any kind.
- R7: irq_o is the OR of all summary bits, delayed by one clock register.
- R8: The priority word at 0x688 is read/write, 32 bits wide, and resets to 0. Offset 0x690 reads the ch_busy_i vector.
- R9: Reads of any other offset return 0. Writes to 0x00, 0x04 to 0x10 and 0x690 change no state.
- R10: After reset every raw bit, mask, priority bit and irq_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_chain_i | input | 16 | Chain-done event pulses, one per channel |
| ev_node_i | input | 16 | Node-done event pulses, one per channel |
| ev_err_a_i | input | 16 | Error kind A pulses, one per channel |
| ev_err_b_i | input | 16 | Error kind B pulses, one per channel |
| ch_busy_i | input | 16 | Per-channel busy flags, reflected at 0x690 |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from the offset |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench takes each of the 64 channel-and-kind pairs in turn. A single one-hot event is raised first with its mask closed and then with it open. This separates the raw, enabled, summary and interrupt paths, and it also exposes any crossing between kinds or between channels.

For every pair the bench writes the complement of the channel's bit to the clear register, then writes the bit itself. The first write shows that only written ones clear, and the second shows that the clear works.

Several further patterns are tried:
- Events of different kinds on different channels with all masks open, to test the OR that forms the summary.
- An event and a clear on the same bit in the same cycle.
- The four-write stop of a single channel.
- Writes to read-only and unmapped offsets, each followed by read-back of every register.

// File: rtl/dis_pkg.sv
package dis_pkg;
  localparam int NKIND = 4;

  localparam int OFS_SUMMARY = 'h000;
  localparam int OFS_PRIO    = 'h688;
  localparam int OFS_BUSY    = 'h690;

  // kind order: 0 chain done, 1 node done, 2 error A, 3 error B
  function automatic int enabled_ofs(input int kind);
    return 'h004 + 4 * kind;
  endfunction

  function automatic int mask_ofs(input int kind);
    return 'h018 + 4 * kind;
  endfunction

  function automatic int clear_ofs(input int kind);
    return 'h600 + 8 * kind;
  endfunction

  // next raw value: clear written ones, then let new events win
  function automatic logic [31:0] raw_next(input logic [31:0] cur,
                                           input logic [31:0] clr,
                                           input logic [31:0] ev);
    return (cur & ~clr) | ev;
  endfunction
endpackage

// File: rtl/dis_event_kind.sv
module dis_event_kind #(
  parameter int NCH = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] ev_i,
  input  logic           mask_we_i,
  input  logic           clr_we_i,
  input  logic [NCH-1:0] wbits_i,
  output logic [NCH-1:0] raw_o,
  output logic [NCH-1:0] mask_o,
  output logic [NCH-1:0] enabled_o
);
  logic [NCH-1:0] raw_q;
  logic [NCH-1:0] mask_q;
  logic [NCH-1:0] clr_mask;
  logic [31:0]    raw_wide;

  assign clr_mask = clr_we_i ? wbits_i : '0;
  assign raw_wide = dis_pkg::raw_next(32'(raw_q), 32'(clr_mask), 32'(ev_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q <= raw_wide[NCH-1:0];
      if (mask_we_i) mask_q <= wbits_i;
    end
  end

  assign raw_o     = raw_q;
  assign mask_o    = mask_q;
  assign enabled_o = raw_q & mask_q;

  // R1: a set raw bit that was not cleared is still set
  a_r1_raw_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(raw_q) & ~$past(clr_mask)) & ~raw_q) == '0));

  // R5: every pulsed bit is set afterwards, even under a clear
  a_r5_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i != '0) |=> ((raw_q & $past(ev_i)) == $past(ev_i)));

  // R4: cleared bits without a new event go to zero
  a_r4_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we_i |=> ((raw_q & $past(clr_mask) & ~$past(ev_i)) == '0));

  // R3: the mask moves only on its own write
  a_r3_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_we_i |=> $stable(mask_q));
endmodule

// File: rtl/dis_reg_decode.sv
module dis_reg_decode #(
  parameter int NCH    = 16,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  localparam int NK    = dis_pkg::NKIND
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [NK-1:0][NCH-1:0] raw_i,
  input  logic [NK-1:0][NCH-1:0] mask_i,
  input  logic [NK-1:0][NCH-1:0] enabled_i,
  input  logic [NCH-1:0]        summary_i,
  input  logic [DATA_W-1:0]     prio_i,
  input  logic [NCH-1:0]        busy_i,
  output logic [NK-1:0]         mask_we_o,
  output logic [NK-1:0]         clr_we_o,
  output logic                  prio_we_o,
  output logic [DATA_W-1:0]     rdata_o
);
  function automatic logic at(input logic [ADDR_W-1:0] a, input int ofs);
    return a == ADDR_W'(ofs);
  endfunction

  always_comb begin
    for (int k = 0; k < NK; k++) begin
      mask_we_o[k] = we_i && at(addr_i, dis_pkg::mask_ofs(k));
      clr_we_o[k]  = we_i && at(addr_i, dis_pkg::clear_ofs(k));
    end
    prio_we_o = we_i && at(addr_i, dis_pkg::OFS_PRIO);
  end

  always_comb begin
    rdata_o = '0;
    if (at(addr_i, dis_pkg::OFS_SUMMARY)) rdata_o[NCH-1:0] = summary_i;
    if (at(addr_i, dis_pkg::OFS_PRIO))    rdata_o = prio_i;
    if (at(addr_i, dis_pkg::OFS_BUSY))    rdata_o[NCH-1:0] = busy_i;
    for (int k = 0; k < NK; k++) begin
      if (at(addr_i, dis_pkg::enabled_ofs(k))) rdata_o[NCH-1:0] = enabled_i[k];
      if (at(addr_i, dis_pkg::mask_ofs(k)))    rdata_o[NCH-1:0] = mask_i[k];
      if (at(addr_i, dis_pkg::clear_ofs(k)))   rdata_o[NCH-1:0] = raw_i[k];
    end
  end

  // R9: a single write never reaches more than one register
  a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mask_we_o, clr_we_o, prio_we_o}));
endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status #(
  parameter int NCH    = 16,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    ev_chain_i,
  input  logic [NCH-1:0]    ev_node_i,
  input  logic [NCH-1:0]    ev_err_a_i,
  input  logic [NCH-1:0]    ev_err_b_i,
  input  logic [NCH-1:0]    ch_busy_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  localparam int NK = dis_pkg::NKIND;

  logic [NK-1:0][NCH-1:0] ev_all;
  logic [NK-1:0][NCH-1:0] raw_all;
  logic [NK-1:0][NCH-1:0] mask_all;
  logic [NK-1:0][NCH-1:0] enabled_all;
  logic [NK-1:0]          mask_we;
  logic [NK-1:0]          clr_we;
  logic                   prio_we;
  logic [NCH-1:0]         summary;
  logic [NCH-1:0]         any_mask;
  logic [DATA_W-1:0]      prio_q;
  logic                   irq_q;

  assign ev_all = {ev_err_b_i, ev_err_a_i, ev_node_i, ev_chain_i};

  for (genvar k = 0; k < NK; k++) begin : g_kind
    dis_event_kind #(.NCH(NCH)) u_kind (
      .clk       (clk),
      .rst_n     (rst_n),
      .ev_i      (ev_all[k]),
      .mask_we_i (mask_we[k]),
      .clr_we_i  (clr_we[k]),
      .wbits_i   (reg_wdata_i[NCH-1:0]),
      .raw_o     (raw_all[k]),
      .mask_o    (mask_all[k]),
      .enabled_o (enabled_all[k])
    );
  end

  always_comb begin
    summary  = '0;
    any_mask = '0;
    for (int k = 0; k < NK; k++) begin
      summary  = summary | enabled_all[k];
      any_mask = any_mask | mask_all[k];
    end
  end

  dis_reg_decode #(.NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .raw_i     (raw_all),
    .mask_i    (mask_all),
    .enabled_i (enabled_all),
    .summary_i (summary),
    .prio_i    (prio_q),
    .busy_i    (ch_busy_i),
    .mask_we_o (mask_we),
    .clr_we_o  (clr_we),
    .prio_we_o (prio_we),
    .rdata_o   (reg_rdata_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (prio_we) prio_q <= reg_wdata_i;
      irq_q <= |summary;
    end
  end

  assign irq_o = irq_q;

  // R7: the line rises only after a pending summary
  a_r7_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(summary != '0));

  // R6: a summary bit needs an open mask on that channel
  a_r6_summary_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (summary & ~any_mask) == '0);

  // R8: priority changes only on its own write
  a_r8_prio_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !prio_we |=> $stable(prio_q));
endmodule

// File: tb/dma_irq_status_test.sv
`timescale 1ns/1ps
module dma_irq_status_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] ev [4];
  logic [15:0] busy = '0;
  logic        we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #4 clk = ~clk;

  dma_irq_status uut (
    .clk(clk), .rst_n(rst_n),
    .ev_chain_i(ev[0]), .ev_node_i(ev[1]), .ev_err_a_i(ev[2]), .ev_err_b_i(ev[3]),
    .ch_busy_i(busy), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  function automatic int ofs_en(int k);  return 4 + k * 4;     endfunction
  function automatic int ofs_msk(int k); return 24 + k * 4;    endfunction
  function automatic int ofs_clr(int k); return 1536 + k * 8;  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(int a, output logic [31:0] v);
    addr = 12'(a);
    #1 v = rdata;
  endtask

  task automatic rdchk(string req, int a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = 12'(a); wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic pulse(int k, logic [15:0] v);
    @(negedge clk);
    ev[k] = v;
    @(negedge clk);
    ev[k] = '0;
  endtask

  task automatic irqchk(string req, logic exp);
    @(negedge clk);
    check(req, {31'b0, irq}, {31'b0, exp});
  endtask

  initial begin
    #1600000;
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: got hang expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 4; k++) ev[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    rdchk("R10 summary", 0, 0);
    for (int k = 0; k < 4; k++) begin
      rdchk("R10 enabled", ofs_en(k), 0);
      rdchk("R10 mask", ofs_msk(k), 0);
      rdchk("R10 raw", ofs_clr(k), 0);
    end
    rdchk("R10 prio", 'h688, 0);
    check("R10 irq", {31'b0, irq}, 0);

    // sweep every kind and channel
    for (int k = 0; k < 4; k++) begin
      for (int c = 0; c < 16; c++) begin
        logic [15:0] b;
        b = 16'(1 << c);
        pulse(k, b);
        rdchk("R1 raw set", ofs_clr(k), {16'b0, b});
        rdchk("R2 closed mask", ofs_en(k), 0);
        rdchk("R6 summary closed", 0, 0);
        irqchk("R7 irq low", 1'b0);
        wr(ofs_msk(k), {16'hffff, b});
        rdchk("R3 mask readback", ofs_msk(k), {16'b0, b});
        rdchk("R2 enabled", ofs_en(k), {16'b0, b});
        for (int o = 0; o < 4; o++)
          if (o != k) rdchk("R2 no cross kind", ofs_clr(o), 0);
        rdchk("R6 summary open", 0, {16'b0, b});
        irqchk("R7 irq high", 1'b1);
        wr(ofs_clr(k), {16'h0, ~b});
        rdchk("R4 others only", ofs_clr(k), {16'b0, b});
        wr(ofs_clr(k), {16'h0, b});
        rdchk("R4 cleared", ofs_clr(k), 0);
        rdchk("R6 summary gone", 0, 0);
        irqchk("R7 irq drops", 1'b0);
        wr(ofs_msk(k), 0);
      end
    end

    // R6 OR across kinds and channels with all masks open
    for (int k = 0; k < 4; k++) wr(ofs_msk(k), 32'hffff);
    @(negedge clk);
    ev[0] = 16'h0001; ev[1] = 16'h0020; ev[2] = 16'h0400; ev[3] = 16'h8001;
    @(negedge clk);
    for (int k = 0; k < 4; k++) ev[k] = '0;
    rdchk("R6 multi summary", 0, 32'h8421);
    rdchk("R2 multi errB", ofs_en(3), 32'h8001);

    // R4 channel stop: clear channel 0 in all four kinds
    for (int k = 0; k < 4; k++) wr(ofs_clr(k), 32'h0001);
    rdchk("R4 stop summary", 0, 32'h8420);
    rdchk("R4 stop errB raw", ofs_clr(3), 32'h8000);
    for (int k = 0; k < 4; k++) wr(ofs_clr(k), 32'hffff);
    rdchk("R4 all clear", 0, 0);

    // R5 event and clear collide
    wr(ofs_clr(1), 0);
    pulse(1, 16'h0300);
    @(negedge clk);
    we = 1'b1; addr = 12'(ofs_clr(1)); wdata = 32'h0300; ev[1] = 16'h0100;
    @(negedge clk);
    we = 1'b0; ev[1] = '0;
    rdchk("R5 event wins", ofs_clr(1), 32'h0100);
    wr(ofs_clr(1), 32'hffff);

    // R8 priority and busy
    wr('h688, 32'hdead_beef);
    rdchk("R8 prio rw", 'h688, 32'hdead_beef);
    wr('h688, 0);
    rdchk("R8 prio zero", 'h688, 0);
    busy = 16'ha5c3;
    rdchk("R8 busy", 'h690, 32'ha5c3);

    // R9 unmapped reads and ignored writes
    rdchk("R9 unmapped 14", 'h014, 0);
    rdchk("R9 unmapped 604", 'h604, 0);
    rdchk("R9 unmapped 700", 'h700, 0);
    wr('h000, 32'hffff);
    wr('h004, 32'hffff);
    wr('h690, 32'hffff);
    wr('h014, 32'h1234);
    rdchk("R9 summary untouched", 0, 0);
    for (int k = 0; k < 4; k++) begin
      rdchk("R9 mask untouched", ofs_msk(k), 32'hffff);
      rdchk("R9 raw untouched", ofs_clr(k), 0);
    end
    rdchk("R9 prio untouched", 'h688, 0);
    rdchk("R9 busy untouched", 'h690, 32'ha5c3);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule